// File: doc/BRIEF.md
# Run-down ADC histogram controller

This block sequences one pulse-height conversion at a time for an analog front end that digitises by linear discharge. A discriminator flag opens the linear gate so the hold capacitor follows the rising pulse. A peak flag then closes the gate and, in the same step, switches on the constant-current discharge and starts a clock counter. The counter stops when a comparator reports that the held voltage has reached zero. The final count is the channel number, so a larger pulse takes more clock cycles to convert.

Each stored conversion ends with a two-cycle read-modify-write that adds one to the histogram bin addressed by the channel number. Bins saturate at their maximum value and do not wrap. A conversion whose count reaches the top channel is reported as an overflow and is not stored. The analog parts stay outside the block. The comparator flag is asynchronous, so it passes through a flip-flop synchroniser. A host port reads any bin. A clear command zeroes the whole spectrum, one address per clock.

Top module: `rdadc_hist`

## Requirements
- R1: After reset, `gate_o`, `rundown_o`, `busy_o`, `done_o` and `ovf_o` are low. While idle, the peak and comparator inputs have no effect unless `lld_i` fires.
- R2: When the block is idle and `lld_i` is high (with `clear_i` low), `gate_o` and `busy_o` go high on the next clock. They stay high until `peak_i` is seen.
- R3: On the clock that samples `peak_i` while the gate is open, `gate_o` falls and `rundown_o` rises, and the cycle counter restarts at 0.
- R4: `zero_raw_i` passes through `SYNC_STAGES` flip-flops. With the default of two stages, if the comparator is raised A cycles after run-down starts, the channel is A+1. `rundown_o` stays high for channel+1 cycles.
- R5: For a stored conversion, the bin at the channel address gains exactly one. `done_o` pulses for one cycle, two cycles after `rundown_o` falls. While `done_o` is high, `chan_o` holds the channel.
- R6: Dead time depends on amplitude. `busy_o` stays high from the gate closing until `done_o`, which is channel+3 cycles, and it is low in the cycle `done_o` is high.
- R7: A count that reaches the top channel 2^CH_W-1 ends the run-down after 2^CH_W cycles. It pulses `ovf_o` with `busy_o` low, and no bin changes.
- R8: A discriminator pulse that arrives while `busy_o` is high is ignored. It does not open the gate afterwards.
- R9: A bin that holds 2^BIN_W-1 keeps that value when it is incremented.
- R10: `clear_i` sampled while idle zeroes all 2^CH_W bins, one per clock. `busy_o` stays high for 2^CH_W cycles. When `clear_i` and `lld_i` are high together, `clear_i` wins.
- R11: A host read returns `host_data_o` for `host_addr_i`, with `host_valid_o` high, one cycle after `host_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lld_i | input | 1 | Low-level discriminator fired |
| peak_i | input | 1 | Peak amplitude detected |
| zero_raw_i | input | 1 | Asynchronous run-down comparator: held voltage at zero |
| clear_i | input | 1 | Zero all histogram bins |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | CH_W | Host read bin address |
| gate_o | output | 1 | Linear gate open (capacitor tracks input) |
| rundown_o | output | 1 | Constant-current discharge enabled |
| busy_o | output | 1 | Dead time / clear in progress |
| chan_o | output | CH_W | Channel number of the last stored conversion |
| done_o | output | 1 | One-cycle pulse: bin incremented |
| ovf_o | output | 1 | One-cycle pulse: conversion overflowed |
| host_data_o | output | BIN_W | Host read data |
| host_valid_o | output | 1 | Host read data valid |

## Verification
The bench uses 32 channels and 4-bit bins. It sweeps the comparator delay over every value from one cycle before the peak up to past the top channel. This reaches every storable channel and shows whether the channel, the run-down length and the dead time scale exactly with amplitude, and where the stored range ends and overflow begins. One amplitude is repeated until its bin saturates, which distinguishes saturation from wrap. A never-zero comparator checks the overflow watchdog path. Discriminator pulses during run-down and clear/discriminator collisions check the rules for ignoring and for priority. A full spectrum readout is compared against an arithmetic model of the histogram.

// File: rtl/rdadc_pkg.sv
package rdadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRACK,
        ST_RUNDOWN,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_CLEAR
    } rd_state_e;

    localparam int MIN_SYNC_STAGES = 2;

    function automatic logic [31:0] pow2(input int bits);
        return 32'd1 << bits;
    endfunction

endpackage

// File: rtl/rdadc_sync.sv
module rdadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= q[i-1];
            end
        end
    end

    assign q_o = q[STAGES-1];
endmodule

// File: rtl/rdadc_seq.sv
module rdadc_seq
    import rdadc_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lld_i,
    input  logic            peak_i,
    input  logic            zero_i,
    input  logic            clear_i,
    output logic            gate_o,
    output logic            rundown_o,
    output logic            busy_o,
    output logic [CH_W-1:0] chan_o,
    output logic            done_o,
    output logic            ovf_o,
    output logic            rmw_rd_o,
    output logic            rmw_wr_o,
    output logic            clr_we_o,
    output logic [CH_W-1:0] clr_addr_o
);
    localparam logic [CH_W-1:0] TOP = '1;

    rd_state_e       state_q;
    logic [CH_W-1:0] cnt_q;
    logic [CH_W-1:0] chan_q;
    logic [CH_W-1:0] clr_q;
    logic            done_q;
    logic            ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            chan_q  <= '0;
            clr_q   <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (clear_i) begin
                        state_q <= ST_CLEAR;
                        clr_q   <= '0;
                    end else if (lld_i) begin
                        state_q <= ST_TRACK;
                    end
                end
                ST_TRACK: begin
                    if (peak_i) begin
                        state_q <= ST_RUNDOWN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUNDOWN: begin
                    if (cnt_q == TOP) begin
                        state_q <= ST_IDLE;
                        ovf_q   <= 1'b1;
                    end else if (zero_i) begin
                        chan_q  <= cnt_q;
                        state_q <= ST_MEM_RD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_MEM_RD: state_q <= ST_MEM_WR;
                ST_MEM_WR: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                ST_CLEAR: begin
                    if (clr_q == TOP) state_q <= ST_IDLE;
                    else              clr_q   <= clr_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign gate_o     = (state_q == ST_TRACK);
    assign rundown_o  = (state_q == ST_RUNDOWN);
    assign busy_o     = (state_q != ST_IDLE);
    assign rmw_rd_o   = (state_q == ST_MEM_RD);
    assign rmw_wr_o   = (state_q == ST_MEM_WR);
    assign clr_we_o   = (state_q == ST_CLEAR);
    assign clr_addr_o = clr_q;
    assign chan_o     = chan_q;
    assign done_o     = done_q;
    assign ovf_o      = ovf_q;

    p_lld_opens_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && lld_i && !clear_i) |=> gate_o);

    p_peak_starts_rundown_r3: assert property (@(posedge clk) disable iff (rst)
        (gate_o && peak_i) |=> (rundown_o && !gate_o && cnt_q == '0));

    p_gate_rundown_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(gate_o && rundown_o));

    p_done_after_write_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(rmw_wr_o) && !busy_o));

    p_ovf_at_top_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(rundown_o) && $past(cnt_q) == TOP && !busy_o));

    p_no_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !gate_o) |=> !gate_o);

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && clear_i) |=> (clr_we_o && !gate_o));

    p_pulses_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(done_o && ovf_o));
endmodule

// File: rtl/rdadc_bins.sv
module rdadc_bins #(
    parameter int CH_W  = 10,
    parameter int BIN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [CH_W-1:0]  addr_i,
    input  logic             clr_we_i,
    input  logic [CH_W-1:0]  clr_addr_i,
    input  logic             host_rd_i,
    input  logic [CH_W-1:0]  host_addr_i,
    output logic [BIN_W-1:0] host_data_o,
    output logic             host_valid_o
);
    localparam int              DEPTH = 1 << CH_W;
    localparam logic [BIN_W-1:0] BMAX = '1;

    logic [BIN_W-1:0] mem [DEPTH];
    logic [BIN_W-1:0] rdata_q;
    logic [BIN_W-1:0] wdata;

    assign wdata = (rdata_q == BMAX) ? BMAX : rdata_q + 1'b1;

    always_ff @(posedge clk) begin
        if (clr_we_i)     mem[clr_addr_i] <= '0;
        else if (wr_en_i) mem[addr_i]     <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q      <= '0;
            host_data_o  <= '0;
            host_valid_o <= 1'b0;
        end else begin
            if (rd_en_i)   rdata_q     <= mem[addr_i];
            if (host_rd_i) host_data_o <= mem[host_addr_i];
            host_valid_o <= host_rd_i;
        end
    end

    p_rmw_pair_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> ($past(rd_en_i) && $stable(addr_i)));

    p_host_valid_r11: assert property (@(posedge clk) disable iff (rst)
        host_rd_i |=> host_valid_o);

    p_write_sources_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(clr_we_i && (wr_en_i || rd_en_i)));
endmodule

// File: rtl/rdadc_hist.sv
module rdadc_hist
    import rdadc_pkg::*;
#(
    parameter int CH_W        = 10,
    parameter int BIN_W       = 24,
    parameter int SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lld_i,
    input  logic             peak_i,
    input  logic             zero_raw_i,
    input  logic             clear_i,
    input  logic             host_rd_i,
    input  logic [CH_W-1:0]  host_addr_i,
    output logic             gate_o,
    output logic             rundown_o,
    output logic             busy_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic [BIN_W-1:0] host_data_o,
    output logic             host_valid_o
);
    logic            zero_s;
    logic            rmw_rd;
    logic            rmw_wr;
    logic            clr_we;
    logic [CH_W-1:0] clr_addr;

    rdadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (zero_raw_i),
        .q_o (zero_s)
    );

    rdadc_seq #(.CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .lld_i      (lld_i),
        .peak_i     (peak_i),
        .zero_i     (zero_s),
        .clear_i    (clear_i),
        .gate_o     (gate_o),
        .rundown_o  (rundown_o),
        .busy_o     (busy_o),
        .chan_o     (chan_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o),
        .rmw_rd_o   (rmw_rd),
        .rmw_wr_o   (rmw_wr),
        .clr_we_o   (clr_we),
        .clr_addr_o (clr_addr)
    );

    rdadc_bins #(.CH_W(CH_W), .BIN_W(BIN_W)) u_bins (
        .clk          (clk),
        .rst          (rst),
        .rd_en_i      (rmw_rd),
        .wr_en_i      (rmw_wr),
        .addr_i       (chan_o),
        .clr_we_i     (clr_we),
        .clr_addr_i   (clr_addr),
        .host_rd_i    (host_rd_i),
        .host_addr_i  (host_addr_i),
        .host_data_o  (host_data_o),
        .host_valid_o (host_valid_o)
    );

    p_busy_covers_r6: assert property (@(posedge clk) disable iff (rst)
        (gate_o || rundown_o) |-> busy_o);
endmodule

// File: tb/rdadc_hist_test.sv
module rdadc_hist_test;
    localparam int CH_W  = 5;
    localparam int BIN_W = 4;
    localparam int NCH   = 1 << CH_W;
    localparam int TOP   = NCH - 1;
    localparam int BMAX  = (1 << BIN_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lld = 1'b0, peak = 1'b0, raw = 1'b0, clr = 1'b0, hrd = 1'b0;
    logic [CH_W-1:0]  haddr = '0;
    logic             gate, rundown, busy, done, ovf, hvalid;
    logic [CH_W-1:0]  chan;
    logic [BIN_W-1:0] hdata;

    int n_chk  = 0;
    int n_fail = 0;
    int model [NCH];

    always #5 clk = ~clk;

    rdadc_hist #(.CH_W(CH_W), .BIN_W(BIN_W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .lld_i(lld), .peak_i(peak), .zero_raw_i(raw),
        .clear_i(clr), .host_rd_i(hrd), .host_addr_i(haddr),
        .gate_o(gate), .rundown_o(rundown), .busy_o(busy), .chan_o(chan),
        .done_o(done), .ovf_o(ovf), .host_data_o(hdata), .host_valid_o(hvalid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_bin(input int a, output int d);
        @(negedge clk);
        haddr = a[CH_W-1:0];
        hrd   = 1'b1;
        @(negedge clk);
        hrd = 1'b0;
        chk(hvalid == 1'b1, "R11 valid", hvalid, 1);
        d = int'(hdata);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++) begin
            int d;
            read_bin(i, d);
            chk(d == model[i], req, d, model[i]);
        end
    endtask

    // a: cycles after run-down start at which comparator rises (-1: one cycle before peak)
    task automatic convert(input int a, input bit poke);
        int rd;
        int exp_chan;
        bit exp_ovf;
        int exp_rd;
        exp_chan = a + 1;
        exp_ovf  = (exp_chan >= TOP);
        exp_rd   = exp_ovf ? TOP + 1 : exp_chan + 1;
        @(negedge clk) lld = 1'b1;
        @(negedge clk) lld = 1'b0;
        chk(gate && busy, "R2 gate open", {gate, busy}, 3);
        @(negedge clk);
        if (a < 0) raw = 1'b1;
        chk(gate && !rundown, "R2 gate held", {gate, rundown}, 2);
        @(negedge clk);
        peak = 1'b1;
        if (a <= 0) raw = 1'b1;
        @(negedge clk);
        peak = 1'b0;
        chk(!gate && rundown, "R3 rundown start", {gate, rundown}, 1);
        rd = 0;
        while (rundown && rd < 4 * NCH) begin
            rd++;
            if (rd >= a) raw = 1'b1;
            lld = (poke && rd == 2);
            @(negedge clk);
        end
        lld = 1'b0;
        if (exp_ovf) begin
            chk(rd == exp_rd, "R7 rundown length", rd, exp_rd);
            chk(ovf && !busy && !done, "R7 ovf pulse", {ovf, busy, done}, 4);
        end else begin
            chk(rd == exp_rd, "R4 rundown length", rd, exp_rd);
            chk(busy && !ovf && !done, "R6 busy in mem cycle", {busy, ovf, done}, 4);
            @(negedge clk);
            chk(busy && !done, "R6 busy in write", {busy, done}, 2);
            @(negedge clk);
            chk(done && !busy, "R5 done pulse", {done, busy}, 2);
            chk(int'(chan) == exp_chan, "R4 channel", chan, exp_chan);
            if (model[exp_chan] < BMAX) model[exp_chan]++;
        end
        raw = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!gate && !busy, "R8 no retrigger", {gate, busy}, 0);
        end
    endtask

    task automatic do_clear(input bit with_lld);
        int cyc;
        @(negedge clk);
        clr = 1'b1;
        lld = with_lld;
        @(negedge clk);
        clr = 1'b0;
        lld = 1'b0;
        cyc = 0;
        while (busy && cyc < 4 * NCH) begin
            chk(!gate, "R10 clear wins", gate, 0);
            cyc++;
            @(negedge clk);
        end
        chk(cyc == NCH, "R10 clear length", cyc, NCH);
        for (int i = 0; i < NCH; i++) model[i] = 0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({gate, rundown, busy, done, ovf} == 5'b0, "R1 reset state",
            {gate, rundown, busy, done, ovf}, 0);

        do_clear(1'b0);
        check_all("R10 bins zero");

        // R1: peak and comparator without discriminator do nothing
        @(negedge clk);
        peak = 1'b1;
        raw  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!gate && !rundown && !busy, "R1 idle ignores", {gate, rundown, busy}, 0);
        end
        peak = 1'b0;
        raw  = 1'b0;
        repeat (3) @(negedge clk);

        // R4 R5 R6 R7: sweep every amplitude
        for (int a = -1; a <= TOP; a++) convert(a, 1'b0);
        convert(4 * NCH, 1'b0);     // comparator never fires: R7
        check_all("R5 spectrum after sweep");

        // R8: discriminator pulses during run-down
        convert(10, 1'b1);
        convert(20, 1'b1);

        // R9: saturation of channel 6
        for (int r = 0; r < BMAX + 4; r++) convert(5, 1'b0);
        check_all("R9 saturated spectrum");

        // R10: clear together with discriminator
        do_clear(1'b1);
        check_all("R10 bins zero after collision");
        convert(3, 1'b0);
        check_all("R5 single hit after clear");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule